// File: doc/BRIEF.md
# Power-Down Entry/Exit Sequencer

This block moves a device into and out of its low-power state on request from an external, asynchronous power-down pin. The request is brought into the input clock domain through a synchronizer chain. Entry is granted only when two conditions hold. The serial control bus must be idle, and a settle interval after the last reset must have run out. A request that arrives while either condition is false is held. It starts as soon as both conditions clear, and it raises a sticky rule-violation flag.

Entry and exit each take a fixed number of input clocks. Both are multiples of a base period that depends on the clock band. The exit interval is much longer than the entry interval. A band-select input chooses the short or long base period, and that choice is captured when each interval starts. While the device is down, the core clock enable is dropped. Serial outputs are held at their last value. The control-bus data-line drive enable is forced off, so the bus is never held low. No state is cleared on entry or exit. A one-cycle restart pulse follows each reset release.

Top module: `pdn_sequencer`

## Requirements
- R1: While rst_n is low, pdn_active=0, hold_out=0, clk_gate_en=1, rule_viol=0 and restart_pulse=0. A reset also returns a device that is down to the active state.
- R2: restart_pulse is high for exactly one cycle, in the first cycle after the first clock edge that follows the release of rst_n.
- R3: With entry allowed, pdn_active rises on the (ENTRY_MULT*base+3)-th rising edge after the request pin rises. base is BASE_LO when band_hi=0 and BASE_HI when band_hi=1. The 3 extra edges are two synchronizer stages and the grant.
- R4: pdn_active falls on the (EXIT_MULT*base+3)-th rising edge after the request pin falls.
- R5: A request seen while bus_busy=1 does not start entry and sets rule_viol. When bus_busy falls, pdn_active rises ENTRY_MULT*base+1 edges later.
- R6: Entry is refused until RST_SETTLE edges have passed after reset release. If the pin is held high through reset, pdn_active rises on edge RST_SETTLE+1+ENTRY_MULT*base, and rule_viol is set.
- R7: While pdn_active=1, hold_out=1 and sda_oe=0 regardless of sda_oe_in. clk_gate_en=0 only in the settled down state; during the exit interval it is 1. While pdn_active=0, sda_oe equals sda_oe_in.
- R8: If the request falls before the entry interval completes, the block returns to active and pdn_active never rises.
- R9: band_hi is sampled when an interval starts. Changing it during an interval does not change that interval's length.
- R10: A request raised during the exit interval does not shorten it. Once the exit completes, a new entry starts, and pdn_active rises again ENTRY_MULT*base+1 edges after it fell.
- R11: rule_viol stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running input clock, also during power-down |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_req_async | input | 1 | Asynchronous power-down request pin |
| band_hi | input | 1 | Clock band select: 0 = low band, 1 = high band |
| bus_busy | input | 1 | Serial control bus activity indicator |
| sda_oe_in | input | 1 | Data-line drive enable from the control-bus logic |
| pdn_active | output | 1 | Device is considered powered down |
| clk_gate_en | output | 1 | Core clock enable, low in the settled down state |
| hold_out | output | 1 | Freeze serial outputs at their last value |
| sda_oe | output | 1 | Qualified data-line drive enable |
| restart_pulse | output | 1 | One-cycle program restart after reset release |
| rule_viol | output | 1 | Sticky flag: request broke the entry rules |

## Verification
Two kinds of event can fall in the same cycle. In the first, a pending request is released by bus_busy falling, or by the reset settle interval running out. The grant must happen on exactly the next edge, and the bench checks this by measuring the edges from the release to the rise of pdn_active. In the second, the exit interval ends while the request pin is already high again. The bench raises the pin part-way through exit, then checks that the fall of pdn_active keeps its full latency and that the re-entry begins on the very next edge.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
   typedef enum logic [1:0] {
      PS_ACTIVE   = 2'd0,
      PS_ENTERING = 2'd1,
      PS_DOWN     = 2'd2,
      PS_EXITING  = 2'd3
   } pdn_state_t;
endpackage

// File: rtl/pdn_sync.sv
module pdn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pdn_rst_ctl.sv
module pdn_rst_ctl #(
   parameter int RST_SETTLE = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic reset_seen,
   output logic restart_pulse
);
   localparam int SW = $clog2(RST_SETTLE + 1);
   localparam logic [SW-1:0] SETTLE_END = SW'(RST_SETTLE);
   localparam logic [SW-1:0] ONE        = SW'(1);

   logic [SW-1:0] settle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  settle_q <= '0;
      else if (settle_q != SETTLE_END) settle_q <= settle_q + ONE;
   end

   assign reset_seen    = (settle_q == SETTLE_END);
   assign restart_pulse = (settle_q == ONE);
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
   import pdn_pkg::*;
#(
   parameter int CW        = 17,
   parameter int ENT_LO_M1 = 1023,
   parameter int ENT_HI_M1 = 2047,
   parameter int EX_LO_M1  = 32767,
   parameter int EX_HI_M1  = 65535
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       band_hi,
   input  logic       bus_busy,
   input  logic       reset_seen,
   output pdn_state_t st,
   output logic       viol
);
   localparam logic [CW-1:0] ENT_LO = CW'(ENT_LO_M1);
   localparam logic [CW-1:0] ENT_HI = CW'(ENT_HI_M1);
   localparam logic [CW-1:0] EX_LO  = CW'(EX_LO_M1);
   localparam logic [CW-1:0] EX_HI  = CW'(EX_HI_M1);
   localparam logic [CW-1:0] ONE    = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          band_q;
   logic [CW-1:0] ent_end;
   logic [CW-1:0] ex_end;

   always_comb begin
      ent_end = band_q ? ENT_HI : ENT_LO;
      ex_end  = band_q ? EX_HI  : EX_LO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= PS_ACTIVE;
         cnt_q  <= '0;
         band_q <= 1'b0;
         viol   <= 1'b0;
      end else begin
         case (st)
            PS_ACTIVE: begin
               if (req) begin
                  if (bus_busy || !reset_seen) begin
                     viol <= 1'b1;
                  end else begin
                     st     <= PS_ENTERING;
                     cnt_q  <= '0;
                     band_q <= band_hi;
                  end
               end
            end
            PS_ENTERING: begin
               if (!req)                 st    <= PS_ACTIVE;
               else if (cnt_q == ent_end) st   <= PS_DOWN;
               else                      cnt_q <= cnt_q + ONE;
            end
            PS_DOWN: begin
               if (!req) begin
                  st     <= PS_EXITING;
                  cnt_q  <= '0;
                  band_q <= band_hi;
               end
            end
            default: begin
               if (cnt_q == ex_end) st    <= PS_ACTIVE;
               else                 cnt_q <= cnt_q + ONE;
            end
         endcase
      end
   end
endmodule

// File: rtl/pdn_sequencer.sv
module pdn_sequencer
   import pdn_pkg::*;
#(
   parameter int BASE_LO     = 256,
   parameter int BASE_HI     = 512,
   parameter int ENTRY_MULT  = 4,
   parameter int EXIT_MULT   = 128,
   parameter int SYNC_STAGES = 2,
   parameter int RST_SETTLE  = 8
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic pdn_req_async,
   input  logic band_hi,
   input  logic bus_busy,
   input  logic sda_oe_in,
   output logic pdn_active,
   output logic clk_gate_en,
   output logic hold_out,
   output logic sda_oe,
   output logic restart_pulse,
   output logic rule_viol
);
   localparam int ENT_LO_LEN = BASE_LO * ENTRY_MULT;
   localparam int ENT_HI_LEN = BASE_HI * ENTRY_MULT;
   localparam int EX_LO_LEN  = BASE_LO * EXIT_MULT;
   localparam int EX_HI_LEN  = BASE_HI * EXIT_MULT;
   localparam int CW         = $clog2(EX_HI_LEN + 1);

   if (BASE_LO < 1 || BASE_HI < BASE_LO) begin : g_bad_base
      $error("pdn_sequencer: need 1 <= BASE_LO <= BASE_HI");
   end
   if (ENTRY_MULT < 1 || EXIT_MULT < ENTRY_MULT) begin : g_bad_mult
      $error("pdn_sequencer: need 1 <= ENTRY_MULT <= EXIT_MULT");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pdn_sequencer: SYNC_STAGES must be at least 2");
   end
   if (RST_SETTLE < 2) begin : g_bad_settle
      $error("pdn_sequencer: RST_SETTLE must be at least 2");
   end

   logic       req_s;
   logic       reset_seen;
   pdn_state_t st;

   pdn_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk_in),
      .rst_n   (rst_n),
      .d_async (pdn_req_async),
      .q_sync  (req_s)
   );

   pdn_rst_ctl #(.RST_SETTLE(RST_SETTLE)) rst_i (
      .clk           (clk_in),
      .rst_n         (rst_n),
      .reset_seen    (reset_seen),
      .restart_pulse (restart_pulse)
   );

   pdn_fsm #(
      .CW        (CW),
      .ENT_LO_M1 (ENT_LO_LEN - 1),
      .ENT_HI_M1 (ENT_HI_LEN - 1),
      .EX_LO_M1  (EX_LO_LEN - 1),
      .EX_HI_M1  (EX_HI_LEN - 1)
   ) fsm_i (
      .clk        (clk_in),
      .rst_n      (rst_n),
      .req        (req_s),
      .band_hi    (band_hi),
      .bus_busy   (bus_busy),
      .reset_seen (reset_seen),
      .st         (st),
      .viol       (rule_viol)
   );

   always_comb begin
      pdn_active  = (st == PS_DOWN) || (st == PS_EXITING);
      hold_out    = pdn_active;
      clk_gate_en = (st != PS_DOWN);
      sda_oe      = sda_oe_in && !pdn_active;
   end
endmodule

// File: rtl/pdn_sequencer_chk.sv
module pdn_sequencer_chk
   import pdn_pkg::*;
(
   input logic       clk_in,
   input logic       rst_n,
   input logic       bus_busy,
   input logic       pdn_active,
   input logic       clk_gate_en,
   input logic       hold_out,
   input logic       sda_oe,
   input logic       restart_pulse,
   input logic       rule_viol,
   input pdn_state_t st
);
   // R7
   sda_off_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      pdn_active |-> !sda_oe);

   // R7
   gate_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      !clk_gate_en |-> hold_out);

   // R2
   restart_once_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      restart_pulse |=> !restart_pulse);

   // R11
   viol_sticky_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      rule_viol |=> rule_viol);

   // R8
   down_after_entry_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      $rose(pdn_active) |-> $past(st) == PS_ENTERING);

   // R5
   grant_idle_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      (st == PS_ENTERING && $past(st) == PS_ACTIVE) |-> !$past(bus_busy));
endmodule

bind pdn_sequencer pdn_sequencer_chk chk_i (
   .clk_in        (clk_in),
   .rst_n         (rst_n),
   .bus_busy      (bus_busy),
   .pdn_active    (pdn_active),
   .clk_gate_en   (clk_gate_en),
   .hold_out      (hold_out),
   .sda_oe        (sda_oe),
   .restart_pulse (restart_pulse),
   .rule_viol     (rule_viol),
   .st            (st)
);

// File: tb/pdn_sequencer_tb.sv
module pdn_sequencer_tb_top;
   localparam int CLK_P  = 10;
   localparam int B_LO   = 4;
   localparam int B_HI   = 8;
   localparam int E_MUL  = 4;
   localparam int X_MUL  = 8;
   localparam int SETTLE = 8;

   logic clk_in = 1'b0;
   logic rst_n, pdn_req_async, band_hi, bus_busy, sda_oe_in;
   logic pdn_active, clk_gate_en, hold_out, sda_oe, restart_pulse, rule_viol;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk_in = ~clk_in;

   pdn_sequencer #(
      .BASE_LO(B_LO), .BASE_HI(B_HI), .ENTRY_MULT(E_MUL),
      .EXIT_MULT(X_MUL), .SYNC_STAGES(2), .RST_SETTLE(SETTLE)
   ) dut_i (
      .clk_in(clk_in), .rst_n(rst_n), .pdn_req_async(pdn_req_async),
      .band_hi(band_hi), .bus_busy(bus_busy), .sda_oe_in(sda_oe_in),
      .pdn_active(pdn_active), .clk_gate_en(clk_gate_en), .hold_out(hold_out),
      .sda_oe(sda_oe), .restart_pulse(restart_pulse), .rule_viol(rule_viol)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk_in);
      #1;
   endtask

   task automatic to_negedge();
      @(negedge clk_in);
   endtask

   // counts rising edges until pdn_active equals target
   task automatic edges_until(input logic target, output int n);
      n = 0;
      do begin
         tick();
         n++;
      end while (pdn_active != target && n < 2000);
   endtask

   task automatic do_reset();
      to_negedge();
      rst_n = 1'b0;
      repeat (3) tick();
      to_negedge();
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int n;
      int lo_e, hi_e, lo_x, hi_x;
      logic seen;
      lo_e = B_LO * E_MUL; hi_e = B_HI * E_MUL;
      lo_x = B_LO * X_MUL; hi_x = B_HI * X_MUL;
      rst_n = 1'b0; pdn_req_async = 1'b0; band_hi = 1'b0;
      bus_busy = 1'b0; sda_oe_in = 1'b1;
      repeat (3) tick();
      // R1 reset state
      check("R1 pdn_active", pdn_active, 0);
      check("R1 hold_out", hold_out, 0);
      check("R1 clk_gate_en", clk_gate_en, 1);
      check("R1 rule_viol", rule_viol, 0);
      check("R1 restart_pulse", restart_pulse, 0);
      to_negedge();
      rst_n = 1'b1;
      tick();
      check("R2 pulse high", restart_pulse, 1);
      tick();
      check("R2 pulse low", restart_pulse, 0);
      repeat (SETTLE + 2) tick();

      // R3 / R4 / R7 per band
      for (int b = 0; b < 2; b++) begin
         to_negedge();
         band_hi = b[0];
         pdn_req_async = 1'b1;
         edges_until(1'b1, n);
         check("R3 entry latency", n, (b ? hi_e : lo_e) + 3);
         check("R7 clk gate down", clk_gate_en, 0);
         check("R7 hold down", hold_out, 1);
         check("R7 sda forced off", sda_oe, 0);
         to_negedge();
         pdn_req_async = 1'b0;
         repeat (4) tick();
         check("R7 gate on while exiting", clk_gate_en, 1);
         check("R7 hold while exiting", hold_out, 1);
         n = 4;
         while (pdn_active && n < 2000) begin tick(); n++; end
         check("R4 exit latency", n, (b ? hi_x : lo_x) + 3);
         check("R7 sda passthrough", sda_oe, 1);
         check("R5 no viol when idle", rule_viol, 0);
      end

      // R8 withdrawal sweep across the whole entry interval
      band_hi = 1'b0;
      for (int k = 1; k <= lo_e; k++) begin
         to_negedge();
         pdn_req_async = 1'b1;
         repeat (k) tick();
         to_negedge();
         pdn_req_async = 1'b0;
         seen = 1'b0;
         repeat (2 * lo_e) begin tick(); seen |= pdn_active; end
         check("R8 withdrawn entry", seen, 0);
      end

      // R9 band change mid-entry
      to_negedge();
      band_hi = 1'b0;
      pdn_req_async = 1'b1;
      repeat (6) tick();
      to_negedge();
      band_hi = 1'b1;
      edges_until(1'b1, n);
      check("R9 latched band", n + 6, lo_e + 3);
      to_negedge();
      band_hi = 1'b0;
      pdn_req_async = 1'b0;

      // R10 request during exit
      repeat (5) tick();
      to_negedge();
      pdn_req_async = 1'b1;
      n = 5;
      while (pdn_active && n < 2000) begin tick(); n++; end
      check("R10 exit not shortened", n, lo_x + 3);
      edges_until(1'b1, n);
      check("R10 re-entry latency", n, lo_e + 1);
      to_negedge();
      pdn_req_async = 1'b0;
      edges_until(1'b0, n);
      check("R4 exit after re-entry", n, lo_x + 3);

      // R5 bus busy defers entry
      to_negedge();
      bus_busy = 1'b1;
      pdn_req_async = 1'b1;
      repeat (lo_e + 10) tick();
      check("R5 held while busy", pdn_active, 0);
      check("R5 viol set", rule_viol, 1);
      to_negedge();
      bus_busy = 1'b0;
      edges_until(1'b1, n);
      check("R5 grant after idle", n, lo_e + 1);
      to_negedge();
      pdn_req_async = 1'b0;
      edges_until(1'b0, n);
      check("R11 viol sticky", rule_viol, 1);

      // R6 request held through reset; reset also leaves DOWN (R1)
      to_negedge();
      pdn_req_async = 1'b1;
      edges_until(1'b1, n);
      to_negedge();
      rst_n = 1'b0;
      #1;
      check("R1 reset leaves down", pdn_active, 0);
      check("R11 viol cleared by reset", rule_viol, 0);
      repeat (2) tick();
      to_negedge();
      rst_n = 1'b1;
      edges_until(1'b1, n);
      check("R6 settle then entry", n, SETTLE + 1 + lo_e);
      check("R6 viol set", rule_viol, 1);
      to_negedge();
      pdn_req_async = 1'b0;
      edges_until(1'b0, n);
      check("R4 final exit", n, lo_x + 3);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule